// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one general-purpose timer channel behind a small register interface. It holds a load register, a read-only current count, a control register and a write-only interrupt clear port. When enabled, the counter steps down by one on each pulse of the tick it has selected. There are two ticks, a fast one and a slow one. Both come from outside as single-cycle enable pulses.

When the count passes below zero, the channel sets a sticky interrupt. In periodic mode the count restarts from the load value. In free-running mode it wraps to all ones. Software stops the channel by writing zero to control. To start it again, software writes control with enable clear, writes the load value, and then writes control with enable set. The rising enable copies the load value into the counter before the first step.

The counter width is a parameter; 16 and 32 bits are the intended settings. Read data is combinational from the address lines and is zero-extended to the bus width.

Top module: `reload_timer`

## Requirements
- R1: After reset the load, value and control registers read zero and the interrupt output is low.
- R2: A write to word offset 0x00 stores the low counter-width bits of the write data as the load value, and a read of 0x00 returns it.
- R3: Control at offset 0x08 keeps bit 7 (enable), bit 6 (periodic) and bit 3 (fast tick select); every other control bit reads as zero.
- R4: A control write that sets bit 7 while the channel is disabled loads the counter from the load register, and the value at offset 0x04 shows it after that write.
- R5: While enabled, the counter drops by one per pulse of the fast tick when bit 3 is set, or of the slow tick when bit 3 is clear; pulses on the other tick have no effect.
- R6: In periodic mode, a tick at count zero reloads the counter from the load register.
- R7: In free-running mode, a tick at count zero wraps the counter to all ones.
- R8: Every underflow sets the interrupt, which stays high until it is cleared.
- R9: A write of any data to offset 0x0C drops the interrupt, and a read of 0x0C returns zero.
- R10: If an underflow and a clear write land in the same cycle, the interrupt remains high.
- R11: Writes to the value register at 0x04 have no effect. While disabled, the counter holds its value and ignores ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| tickFast | input | 1 | Fast tick enable pulse |
| tickSlow | input | 1 | Slow tick enable pulse |
| irq | output | 1 | Sticky underflow interrupt |

## Verification
The bound checker watches these rules on every cycle:
- An underflow always sets the interrupt.
- The interrupt holds until a clear write.
- A clear write with no underflow in the same cycle drops the interrupt.
- The counter moves only on a start or a selected tick.
- Underflow goes to the load value in periodic mode and to all ones in free-running mode.
- The clear port reads zero.

Other behaviour needs the directed scenarios in the bench:
- The tick selection itself, and ignoring the unselected tick.
- Loading the counter when enable rises.
- Masking of unused control bits.
- Ignoring writes to the value register.
- The collision of an underflow with a clear write.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
  localparam int OFF_LOAD  = 0;
  localparam int OFF_VALUE = 1;
  localparam int OFF_CTRL  = 2;
  localparam int OFF_CLEAR = 3;
  localparam int BIT_EN    = 7;
  localparam int BIT_PER   = 6;
  localparam int BIT_FAST  = 3;

  typedef struct packed {
    logic loadWr;
    logic startLoad;
    logic decEn;
    logic periodic;
  } strobes_t;
endpackage

// File: rtl/rtimer_ctrl.sv
module rtimer_ctrl
  import rtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickFast,
  input  logic              tickSlow,
  input  logic              underflow,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  loadVal,
  output strobes_t          stb,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic wrAny, wrLoad, wrCtrl, wrClear;
  logic ctrlEn, ctrlPer, ctrlFast;
  logic selTick;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign wrAny   = busValid && busWrite;
  assign wrLoad  = wrAny && (wordIdx == IDX_W'(OFF_LOAD));
  assign wrCtrl  = wrAny && (wordIdx == IDX_W'(OFF_CTRL));
  assign wrClear = wrAny && (wordIdx == IDX_W'(OFF_CLEAR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      ctrlPer  <= 1'b0;
      ctrlFast <= 1'b0;
    end else if (wrCtrl) begin
      ctrlEn   <= busWdata[BIT_EN];
      ctrlPer  <= busWdata[BIT_PER];
      ctrlFast <= busWdata[BIT_FAST];
    end
  end

  // A fresh underflow outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)          irq <= 1'b0;
    else if (underflow) irq <= 1'b1;
    else if (wrClear)   irq <= 1'b0;
  end

  assign selTick = ctrlFast ? tickFast : tickSlow;

  always_comb begin
    stb.loadWr    = wrLoad;
    stb.startLoad = wrCtrl && busWdata[BIT_EN] && !ctrlEn;
    stb.decEn     = ctrlEn && selTick;
    stb.periodic  = ctrlPer;
  end

  always_comb begin
    busRdata = '0;
    case (wordIdx)
      IDX_W'(OFF_LOAD):  busRdata = DATA_W'(loadVal);
      IDX_W'(OFF_VALUE): busRdata = DATA_W'(count);
      IDX_W'(OFF_CTRL): begin
        busRdata[BIT_EN]   = ctrlEn;
        busRdata[BIT_PER]  = ctrlPer;
        busRdata[BIT_FAST] = ctrlFast;
      end
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/rtimer_dpath.sv
module rtimer_dpath
  import rtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  loadVal,
  output logic              underflow
);
  assign underflow = stb.decEn && (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN)           loadVal <= '0;
    else if (stb.loadWr) loadVal <= wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              count <= '0;
    else if (stb.startLoad) count <= loadVal;
    else if (underflow)     count <= stb.periodic ? loadVal : '1;
    else if (stb.decEn)     count <= count - 1'b1;
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickFast,
  input  logic              tickSlow,
  output logic              irq
);
  strobes_t         stb;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] loadVal;
  logic             underflow;

  rtimer_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickFast(tickFast), .tickSlow(tickSlow), .underflow(underflow),
    .count(count), .loadVal(loadVal), .stb(stb), .irq(irq)
  );

  rtimer_dpath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .count(count), .loadVal(loadVal), .underflow(underflow)
  );
endmodule

// File: rtl/rtimer_chk.sv
module rtimer_chk
  import rtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              irq,
  input logic              underflow,
  input strobes_t          stb,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  loadVal
);
  logic clearWr, clearAddr;
  assign clearAddr = (busAddr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_CLEAR));
  assign clearWr   = busValid && busWrite && clearAddr;

  assert_underflow_sets_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> irq);
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clearWr) |=> irq);
  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clearWr && !underflow) |=> !irq);
  assert_clear_reads_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    clearAddr |-> (busRdata == '0));
  assert_collision_keeps_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clearWr && underflow) |=> irq);
  assert_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && stb.periodic) |=> (count == $past(loadVal)));
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !stb.periodic) |=> (count == {CNT_W{1'b1}}));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.decEn && !stb.startLoad) |=> $stable(count));
endmodule

bind reload_timer rtimer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busRdata(busRdata), .irq(irq), .underflow(underflow),
  .stb(stb), .count(count), .loadVal(loadVal)
);

// File: tb/reload_timer_tb_top.sv
module reload_timer_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic tickFast = 1'b0, tickSlow = 1'b0;
  logic irq;
  int nChecks = 0, nFails = 0;

  always #10 clk = ~clk;

  reload_timer #(.CNT_W(32), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickFast(tickFast), .tickSlow(tickSlow), .irq(irq)
  );

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdCheck(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    busAddr = a;
    #1;
    check(busRdata, exp, tag);
  endtask

  task automatic tick(input logic fast, input logic slow, input logic clr);
    @(negedge clk);
    tickFast = fast; tickSlow = slow;
    if (clr) begin
      busValid = 1'b1; busWrite = 1'b1; busAddr = 4'hC; busWdata = 32'h5A;
    end
    @(negedge clk);
    tickFast = 1'b0; tickSlow = 1'b0; busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic startTimer(input logic [DW-1:0] mode, input logic [DW-1:0] ld);
    wr(4'h8, mode & ~32'h80);
    wr(4'h0, ld);
    wr(4'h8, mode | 32'h80);
  endtask

  task automatic testReset();
    rdCheck(4'h0, 0, "R1 load");
    rdCheck(4'h4, 0, "R1 value");
    rdCheck(4'h8, 0, "R1 ctrl");
    check(DW'(irq), 0, "R1 irq");
  endtask

  task automatic testRegs();
    wr(4'h0, 32'h1234_5678);
    rdCheck(4'h0, 32'h1234_5678, "R2 load readback");
    wr(4'hC, 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    rdCheck(4'h8, 32'h0000_00C8, "R3 ctrl mask");
    wr(4'h8, 32'h0);
    rdCheck(4'h8, 32'h0, "R3 ctrl stop");
    wr(4'h4, 32'hAAAA_AAAA);
    rdCheck(4'h4, 32'h1234_5678, "R11 value write ignored");
  endtask

  task automatic testPeriodic();
    startTimer(32'h48, 32'd3);
    rdCheck(4'h4, 32'd3, "R4 start load");
    tick(1'b0, 1'b1, 1'b0);
    rdCheck(4'h4, 32'd3, "R5 slow ignored");
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b0);
    rdCheck(4'h4, 32'd0, "R5 fast decrements");
    check(DW'(irq), 0, "R8 no irq before underflow");
    tick(1'b1, 1'b0, 1'b0);
    rdCheck(4'h4, 32'd3, "R6 reload");
    check(DW'(irq), 1, "R8 irq set");
    tick(1'b1, 1'b0, 1'b0);
    rdCheck(4'h4, 32'd2, "R6 count after reload");
    check(DW'(irq), 1, "R8 irq sticky");
    wr(4'hC, 32'hDEAD_BEEF);
    check(DW'(irq), 0, "R9 clear");
    rdCheck(4'hC, 32'h0, "R9 clear reads zero");
  endtask

  task automatic testFreeRun();
    startTimer(32'h00, 32'd1);
    rdCheck(4'h4, 32'd1, "R4 start load free");
    tick(1'b1, 1'b0, 1'b0);
    rdCheck(4'h4, 32'd1, "R5 fast ignored");
    tick(1'b0, 1'b1, 1'b0);
    rdCheck(4'h4, 32'd0, "R5 slow decrements");
    tick(1'b0, 1'b1, 1'b0);
    rdCheck(4'h4, 32'hFFFF_FFFF, "R7 wrap");
    check(DW'(irq), 1, "R8 irq free-run");
    wr(4'hC, 32'h0);
  endtask

  task automatic testCollision();
    startTimer(32'h48, 32'd0);
    tick(1'b1, 1'b0, 1'b0);
    check(DW'(irq), 1, "R8 irq at zero load");
    tick(1'b1, 1'b0, 1'b1);
    check(DW'(irq), 1, "R10 underflow beats clear");
    wr(4'hC, 32'h0);
    check(DW'(irq), 0, "R9 clear after collision");
  endtask

  task automatic testHold();
    startTimer(32'h48, 32'd5);
    tick(1'b1, 1'b0, 1'b0);
    rdCheck(4'h4, 32'd4, "R5 decrement");
    wr(4'h8, 32'h0);
    tick(1'b1, 1'b1, 1'b0);
    rdCheck(4'h4, 32'd4, "R11 disabled hold");
    check(DW'(irq), 0, "R11 no irq while disabled");
  endtask

  initial begin
    #(20 * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testPeriodic();
    testFreeRun();
    testCollision();
    testHold();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule